// File: doc/BRIEF.md
# USB Token Packet Serializer

This block turns one token request (a 4-bit token type, a 7-bit device address and a 4-bit endpoint number) into the bit stream that goes on the wire. The packet opens with a synchronisation field. The packet identifier follows, made of the type and its bitwise complement. Next come the address and the endpoint. A 5-bit CRC over the address and endpoint closes the packet. After the synchronisation field, a zero is stuffed into the stream after every run of six ones. The stuffed stream is then NRZI encoded, and the block emits one line level per clock.

Requests enter through a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from that edge until the packet's last bit has been produced internally, so a source holds its request until it is taken. The line side has no back-pressure. Once a packet starts, `line_valid` stays high for one bit per clock up to the bit marked by `line_eop`. When no packet is on the line, the level rests high.

Top module: `tokser_top`

## Requirements
- R1: After reset `req_ready` is high. It drops on the edge that accepts a request and stays low until that packet's final bit has been produced. A request is accepted only when `req_valid` and `req_ready` are both high at a clock edge.
- R2: The unstuffed bit order is as follows. First come seven 0s and then a 1. Next come the 4 type bits, LSB first, then the 4 bits of the complemented type, LSB first. The 7 address bits follow LSB first, then the 4 endpoint bits LSB first, then the 5 CRC bits.
- R3: The CRC uses the generator x^5+x^2+1 with a register preset to 11111. It takes the address bits 0..6 and then the endpoint bits 0..3, one bit at a time. At each step the feedback is the input bit XOR register bit 4, the register shifts left, and the mask 00101 is XORed in when the feedback is 1. The inverted final register is sent starting with bit 4.
- R4: The ones counter starts at zero at the first identifier bit and ignores the synchronisation field. It resets on every 0 bit and on every stuffed bit. After six consecutive 1s a 0 is inserted, and this also happens when the last CRC bit completes the run.
- R5: NRZI coding works as follows. A 0 toggles the line and a 1 holds it. The level before a packet's first bit is taken as 1. `line_bit` is 1 whenever `line_valid` is low.
- R6: `line_valid` stays high without a break for every bit of a packet, including stuffed bits. `line_eop` is high only together with the packet's last emitted bit, and the cycle after it has `line_valid` low.
- R7: Values on the request inputs while `req_ready` is low, `req_valid` included, have no effect on the packet in flight or on any later packet.
- R8: During and straight after reset, `line_valid` and `line_eop` are low and `line_bit` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A token request is offered |
| req_ready | output | 1 | The block can take a request |
| req_type | input | 4 | Token type nibble |
| req_addr | input | 7 | Device address |
| req_endp | input | 4 | Endpoint number |
| line_valid | output | 1 | `line_bit` carries a packet bit this cycle |
| line_bit | output | 1 | NRZI line level |
| line_eop | output | 1 | Marks the final bit of a packet |

## Verification
The hardest case to reach from the ports is a stuffed zero that lands after the last CRC bit. Only a few address/endpoint pairs end their CRC on the sixth one of a run, and random requests rarely hit one. The bench therefore searches the whole address and endpoint space with its own reference model, picks a pair that produces such a trailing stuff, and sends it as a directed case. It also sends an all-ones request that forces stuffing across the field boundaries. While each packet is busy, the bench drives garbage with `req_valid` high to show that it is ignored.

// File: rtl/tokser_pkg.sv
package tokser_pkg;
  localparam int TYPE_W  = 4;
  localparam int ADDR_W  = 7;
  localparam int ENDP_W  = 4;
  localparam int SYNC_W  = 8;
  localparam int CRC_W   = 5;
  localparam int FIELD_W = ADDR_W + ENDP_W;
  localparam int FRAME_W = SYNC_W + 2 * TYPE_W + FIELD_W + CRC_W;
  localparam logic [CRC_W-1:0] CRC_POLY = 5'b00101;

  // Residue over the address/endpoint field (address first, each LSB first), inverted
  function automatic logic [CRC_W-1:0] crc_field(input logic [FIELD_W-1:0] fld);
    logic [CRC_W-1:0] acc;
    logic fb;
    acc = '1;
    for (int i = 0; i < FIELD_W; i++) begin
      fb  = fld[i] ^ acc[CRC_W-1];
      acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return ~acc;
  endfunction
endpackage

// File: rtl/tokser_framer.sv
module tokser_framer
  import tokser_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TYPE_W-1:0] tok_type,
  input  logic [ADDR_W-1:0] tok_addr,
  input  logic [ENDP_W-1:0] tok_endp,
  input  logic              adv,
  output logic              busy,
  output logic              cur_bit,
  output logic              in_sync,
  output logic              last
);
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam int PID_LO  = SYNC_W;
  localparam int FLD_LO  = SYNC_W + 2 * TYPE_W;
  localparam int CRC_LO  = FLD_LO + FIELD_W;

  logic [FRAME_W-1:0] frame, sh_q;
  logic [IDX_W-1:0]   idx_q;
  logic               busy_q;
  logic [CRC_W-1:0]   crc;

  assign crc = crc_field({tok_endp, tok_addr});

  always_comb begin
    frame = '0;
    frame[SYNC_W-1] = 1'b1;
    frame[PID_LO +: TYPE_W]          = tok_type;
    frame[PID_LO + TYPE_W +: TYPE_W] = ~tok_type;
    frame[FLD_LO +: ADDR_W]          = tok_addr;
    frame[FLD_LO + ADDR_W +: ENDP_W] = tok_endp;
    for (int i = 0; i < CRC_W; i++)
      frame[CRC_LO + i] = crc[CRC_W-1-i];
  end

  assign busy    = busy_q;
  assign cur_bit = sh_q[0];
  assign last    = (idx_q == IDX_W'(FRAME_W - 1));
  assign in_sync = (idx_q < IDX_W'(SYNC_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else if (load) begin
      sh_q   <= frame;
      idx_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q && adv) begin
      sh_q  <= sh_q >> 1;
      idx_q <= idx_q + 1'b1;
      if (last) busy_q <= 1'b0;
    end
  end

  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy_q); // R1
  AST_HOLD_WITHOUT_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !adv && !load) |=> (busy_q && $stable(idx_q))); // R4
endmodule

// File: rtl/tokser_stuff.sv
module tokser_stuff #(
  parameter int RUN_MAX = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic cur_bit,
  input  logic in_sync,
  input  logic last,
  output logic adv,
  output logic raw_valid,
  output logic raw_bit,
  output logic raw_eop,
  output logic no_pending
);
  localparam int CNT_W = $clog2(RUN_MAX + 1);

  logic [CNT_W-1:0] ones_q, ones_nxt;
  logic             stuff_now;

  assign stuff_now  = (ones_q == CNT_W'(RUN_MAX));
  assign no_pending = !stuff_now;
  assign raw_valid  = busy || stuff_now;
  assign adv        = busy && !stuff_now;
  assign raw_bit    = stuff_now ? 1'b0 : cur_bit;

  always_comb begin
    if (stuff_now)                   ones_nxt = '0;
    else if (!busy)                  ones_nxt = ones_q;
    else if (in_sync || !cur_bit)    ones_nxt = '0;
    else                             ones_nxt = ones_q + 1'b1;
  end

  assign raw_eop = stuff_now ? !busy
                             : (busy && last && ones_nxt != CNT_W'(RUN_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ones_q <= '0;
    else        ones_q <= ones_nxt;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= CNT_W'(RUN_MAX)); // R4
  AST_STUFF_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_valid && $past(ones_q) == CNT_W'(RUN_MAX - 1) && ones_q == CNT_W'(RUN_MAX)) |-> !raw_bit); // R4
endmodule

// File: rtl/tokser_nrzi.sv
module tokser_nrzi (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_valid,
  input  logic raw_bit,
  input  logic raw_eop,
  output logic line_valid,
  output logic line_bit,
  output logic line_eop
);
  logic base;

  assign base = (line_eop || !line_valid) ? 1'b1 : line_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_valid <= 1'b0;
      line_bit   <= 1'b1;
      line_eop   <= 1'b0;
    end else begin
      line_valid <= raw_valid;
      line_eop   <= raw_valid && raw_eop;
      line_bit   <= raw_valid ? (raw_bit ? base : ~base) : 1'b1;
    end
  end

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !line_valid |-> line_bit); // R5
  AST_ZERO_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_valid && !raw_bit && line_valid && !line_eop) |=> (line_bit != $past(line_bit))); // R5
  AST_EOP_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    line_eop |-> line_valid); // R6
  AST_GAP_AFTER_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    line_eop |=> !line_valid); // R6
endmodule

// File: rtl/tokser_top.sv
module tokser_top
  import tokser_pkg::*;
#(
  parameter int RUN_MAX = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [TYPE_W-1:0] req_type,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ENDP_W-1:0] req_endp,
  output logic              line_valid,
  output logic              line_bit,
  output logic              line_eop
);
  logic busy, cur_bit, in_sync, last, adv, load;
  logic raw_valid, raw_bit, raw_eop, no_pending;

  assign req_ready = !busy && no_pending;
  assign load      = req_valid && req_ready;

  tokser_framer u_framer (
    .clk(clk), .rst_n(rst_n), .load(load),
    .tok_type(req_type), .tok_addr(req_addr), .tok_endp(req_endp),
    .adv(adv), .busy(busy), .cur_bit(cur_bit), .in_sync(in_sync), .last(last)
  );

  tokser_stuff #(.RUN_MAX(RUN_MAX)) u_stuff (
    .clk(clk), .rst_n(rst_n), .busy(busy), .cur_bit(cur_bit),
    .in_sync(in_sync), .last(last), .adv(adv), .raw_valid(raw_valid),
    .raw_bit(raw_bit), .raw_eop(raw_eop), .no_pending(no_pending)
  );

  tokser_nrzi u_nrzi (
    .clk(clk), .rst_n(rst_n), .raw_valid(raw_valid), .raw_bit(raw_bit),
    .raw_eop(raw_eop), .line_valid(line_valid), .line_bit(line_bit),
    .line_eop(line_eop)
  );

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R1
endmodule

// File: tb/test_tokser_top.sv
module test_tokser_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [3:0] req_type = '0;
  logic [6:0] req_addr = '0;
  logic [3:0] req_endp = '0;
  logic line_valid, line_bit, line_eop;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  logic [14:0] exp_q[$];
  logic        e_lvl[0:63];
  int          e_len;
  bit          e_tail;
  int          pos = 0;
  bit          collecting = 0;

  always #2 clk = ~clk;  // 250 MHz

  tokser_top i_tokser_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_type(req_type), .req_addr(req_addr), .req_endp(req_endp),
    .line_valid(line_valid), .line_bit(line_bit), .line_eop(line_eop)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference: fills e_lvl / e_len / e_tail with the expected line levels
  task automatic compute(input logic [3:0] t, input logic [6:0] a, input logic [3:0] e);
    logic r[0:31];
    logic [4:0] c;
    logic d, lvl;
    int n, ones;
    n = 0;
    for (int k = 0; k < 7; k++) begin r[n] = 1'b0; n++; end
    r[n] = 1'b1; n++;
    for (int k = 0; k < 4; k++) begin r[n] = t[k]; n++; end
    for (int k = 0; k < 4; k++) begin r[n] = ~t[k]; n++; end
    for (int k = 0; k < 7; k++) begin r[n] = a[k]; n++; end
    for (int k = 0; k < 4; k++) begin r[n] = e[k]; n++; end
    c = 5'h1f;
    for (int k = 0; k < 11; k++) begin
      d = (k < 7) ? a[k] : e[k-7];
      if (d ^ c[4]) c = {c[3:0], 1'b0} ^ 5'h05;
      else          c = {c[3:0], 1'b0};
    end
    c = ~c;
    for (int k = 4; k >= 0; k--) begin r[n] = c[k]; n++; end
    ones = 0; e_len = 0; e_tail = 0; lvl = 1'b1;
    for (int k = 0; k < 32; k++) begin
      lvl = r[k] ? lvl : ~lvl;
      e_lvl[e_len] = lvl; e_len++;
      if (k < 8) ones = 0;
      else if (r[k]) ones++;
      else ones = 0;
      if (ones == 6) begin
        lvl = ~lvl;
        e_lvl[e_len] = lvl; e_len++;
        ones = 0;
        if (k == 31) e_tail = 1;
      end
    end
  endtask

  // Output monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (line_valid) begin
        if (!collecting) begin
          if (exp_q.size() == 0) begin
            check(0, "R7 unexpected packet", 1, 0);
            e_len = 0;
          end else begin
            logic [14:0] x;
            x = exp_q.pop_front();
            compute(x[14:11], x[10:4], x[3:0]);
          end
          collecting = 1; pos = 0;
        end
        if (pos < e_len)
          check(line_bit == e_lvl[pos], "R2 R3 R4 R5 R7 line level", int'(line_bit), int'(e_lvl[pos]));
        pos++;
        if (line_eop) begin
          check(pos == e_len, "R6 eop position (bits)", pos, e_len);
          collecting = 0;
        end else if (pos >= e_len) begin
          check(0, "R6 missing eop", pos, e_len);
          collecting = 0;
        end
      end else begin
        if (collecting) begin
          check(0, "R6 valid dropped mid packet", pos, e_len);
          collecting = 0;
        end
        if (!line_bit) check(0, "R5 idle level", int'(line_bit), 1);
        if (line_eop)  check(0, "R6 eop without valid", 1, 0);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic send(input logic [3:0] t, input logic [6:0] a, input logic [3:0] e);
    int guard;
    @(negedge clk);
    req_valid = 1'b1; req_type = t; req_addr = a; req_endp = e;
    guard = 0;
    while (!req_ready && guard < 200) begin @(negedge clk); guard++; end
    exp_q.push_back({t, a, e});
    @(negedge clk);
    check(!req_ready, "R1 ready low after accept", int'(req_ready), 0);
    // garbage while busy, valid held high
    req_type = 4'($urandom); req_addr = 7'($urandom); req_endp = 4'($urandom);
    @(negedge clk);
    req_valid = 1'b0;
    req_type = 4'($urandom); req_addr = 7'($urandom); req_endp = 4'($urandom);
    repeat ($urandom_range(0, 3)) @(negedge clk);
  endtask

  initial begin
    bit found;
    logic [6:0] ta;
    logic [3:0] te;
    void'($urandom(32'h5eed_7a11));
    repeat (3) @(negedge clk);
    check(!line_valid && line_bit && !line_eop, "R8 outputs in reset",
          {line_valid, line_bit, line_eop}, 3'b010);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready, "R1 ready after reset", int'(req_ready), 1);
    check(!line_valid && line_bit && !line_eop, "R8 outputs after reset",
          {line_valid, line_bit, line_eop}, 3'b010);

    // search for a request whose CRC tail forces a trailing stuffed zero (R4)
    found = 0; ta = '0; te = '0;
    for (int a = 0; a < 128 && !found; a++)
      for (int e = 0; e < 16 && !found; e++) begin
        compute(4'h9, 7'(a), 4'(e));
        if (e_tail) begin found = 1; ta = 7'(a); te = 4'(e); end
      end
    check(found, "R4 trailing stuff case exists", int'(found), 1);

    send(4'h0, 7'h00, 4'h0);
    send(4'hF, 7'h7F, 4'hF);  // long runs of ones: R4 across field boundaries
    send(4'h9, ta, te);       // R4 trailing stuff after last CRC bit
    send(4'h1, 7'h55, 4'hA);
    for (int i = 0; i < 300; i++)
      send(4'($urandom), 7'($urandom), 4'($urandom));

    repeat (80) @(negedge clk);
    check(exp_q.size() == 0, "R6 all packets delivered", exp_q.size(), 0);
    check(req_ready, "R1 ready when idle", int'(req_ready), 1);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule